// File: doc/BRIEF.md
# Two-Stage Interleaved Window Router

This block sits behind a fixed slice of the host address map and steers every access in that slice to one root port of one host bridge. An access arrives with an offset measured from the start of the window. The block adds the programmed window base to get the host physical address. It then runs two interleave decodes in a row. The window stage spreads the address over the bridges. The chosen bridge's decoder spreads it again over the entries of a packed port list.

Each stage has its own encoded granularity and its own encoded way count. A bridge decoder only routes traffic once its commit bit is set. An access that cannot be placed is answered locally as a miss: a read gets zero data and an error, and a write is dropped and reported as a success. Successful accesses leave through a valid/ready forward port. The forward port carries the bridge, the port number, the host address, the byte count and the write data unchanged.

Configuration lives in a small word-addressed register file inside the block. That file holds the window base, the window size in MiB, and the window interleave control. For each bridge it holds the decoder control, two target-list words and a port-presence mask. Writes that would program an illegal value are refused and flagged.

Top module: `ilv_window_router`

## Requirements
- R1: The window size register (word 2) holds the size in MiB. A write whose low 8 bits are not all zero is not a whole multiple of 256 MiB. Such a write is refused: `cfg_err` pulses in the next cycle and the register keeps its old value. Legal writes give `cfg_err` = 0.
- R2: A forwarded access carries `fwd_hpa` equal to the window base (words 0 and 1, low and high parts) plus `req_offset`.
- R3: The bridge is (HPA >> (8+G)) mod 2^W. G is the window granularity code in bits [3:0] of word 3, and code n means 256<<n bytes. W is the window way code in bits [7:4] of word 3. After reset both codes are 0, giving 256-byte granularity and a single bridge.
- R4: Each bridge b has a decoder control word at 8+4b. Bits [3:0] hold the granularity code, bits [7:4] the way code and bit 8 the commit bit. An access whose selected bridge has the commit bit clear is a miss.
- R5: The list index is k = (HPA >> (8+g)) mod 2^w, using that decoder's codes. The port is byte k of the 64-bit list. Entries 0-3 are in the low word (9+4b), entries 4-7 in the high word (10+4b), and entry k sits in byte k mod 4.
- R6: The presence word (11+4b) has bit p set when port p has a device. A port number of PORTS or more, or one whose presence bit is clear, is a miss.
- R7: A read miss answers one cycle after acceptance with `miss_valid`=1, `miss_err`=1 and `miss_rdata`=0, and nothing is forwarded.
- R8: A write miss answers with `miss_valid`=1 and `miss_err`=0 (success), and nothing is forwarded.
- R9: `req_len` is the byte count minus one (1 to 8 bytes). Any byte alignment is accepted. Length, write flag and little-endian write data are forwarded unchanged.
- R10: An offset at or beyond the window size is a miss.
- R11: A window control write with granularity code above 6 is refused with `cfg_err`, and so is one with a way code above log2(NB). A decoder control write with granularity code above 6 is refused the same way, and so is one with a way code above 3. The stored value stays unchanged.
- R12: After reset nothing is pending. While `fwd_valid` is held without `fwd_ready`, `req_ready` is low and the forward fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(9+4*NB) | Configuration word address (read and write) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| cfg_err | output | 1 | Pulses one cycle after a refused write |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Offset from window start |
| req_len | input | 3 | Byte count minus one |
| req_wdata | input | 64 | Little-endian write data |
| fwd_valid | output | 1 | Routed access valid |
| fwd_ready | input | 1 | Downstream takes routed access |
| fwd_write | output | 1 | Routed access direction |
| fwd_bridge | output | $clog2(NB) | Selected host bridge |
| fwd_port | output | 8 | Selected root port number |
| fwd_hpa | output | ADDR_W | Host physical address |
| fwd_len | output | 3 | Byte count minus one |
| fwd_wdata | output | 64 | Write data |
| miss_valid | output | 1 | Local miss answer valid |
| miss_err | output | 1 | 1 for a read miss, 0 for a write miss |
| miss_rdata | output | 64 | Read data of a miss (zero) |

## Verification
The hardest cases to reach are the ones where the two stages disagree. In one, the window stage picks a bridge that is committed, but its second stage lands on a list entry naming an absent or out-of-range port. In another, the window stage lands on an uncommitted bridge. The stimulus programs four bridges with different granularities, way counts, commit states and presence masks, so that a sweep over the address bits feeding both stages walks through every combination. The sweep also crosses a window size change, so one offset moves from outside the window to inside.

// File: rtl/ilv_window_router.sv
module ilv_window_router #(
  parameter int ADDR_W = 48,
  parameter int NB     = 4,
  parameter int PORTS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(9+4*NB)-1:0]  cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  output logic                       cfg_err,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_offset,
  input  logic [2:0]                 req_len,
  input  logic [63:0]                req_wdata,
  output logic                       fwd_valid,
  input  logic                       fwd_ready,
  output logic                       fwd_write,
  output logic [$clog2(NB)-1:0]      fwd_bridge,
  output logic [7:0]                 fwd_port,
  output logic [ADDR_W-1:0]          fwd_hpa,
  output logic [2:0]                 fwd_len,
  output logic [63:0]                fwd_wdata,
  output logic                       miss_valid,
  output logic                       miss_err,
  output logic [63:0]                miss_rdata
);

  localparam int BW  = $clog2(NB);
  localparam int PW  = $clog2(PORTS);
  localparam int CAW = $clog2(9+4*NB);
  localparam int SW  = (ADDR_W > 52) ? ADDR_W : 52;

  logic [ADDR_W-1:0] win_base;
  logic [31:0]       size_mb;
  logic [2:0]        win_ig;
  logic [3:0]        win_iw;
  logic [2:0]        dec_ig  [NB];
  logic [1:0]        dec_iw  [NB];
  logic              dec_com [NB];
  logic [31:0]       dec_lo  [NB];
  logic [31:0]       dec_hi  [NB];
  logic [PORTS-1:0]  dec_pres[NB];

  wire [CAW-1:0] cfg_rel   = cfg_addr - CAW'(8);
  wire           cfg_is_br = (cfg_addr >= CAW'(8)) && (cfg_addr < CAW'(8+4*NB));
  wire [BW-1:0]  cfg_br    = BW'(cfg_rel >> 2);

  logic cfg_reject;
  always_comb begin
    cfg_reject = 1'b0;
    if (cfg_is_br) begin
      if (cfg_addr[1:0] == 2'd0)
        cfg_reject = (cfg_wdata[3:0] > 4'd6) || (cfg_wdata[7:4] > 4'd3);
    end else begin
      case (cfg_addr)
        CAW'(2): cfg_reject = cfg_wdata[7:0] != 8'd0;
        CAW'(3): cfg_reject = (cfg_wdata[3:0] > 4'd6) || (cfg_wdata[7:4] > 4'(BW));
        default: cfg_reject = 1'b0;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = 32'd0;
    if (cfg_is_br) begin
      case (cfg_addr[1:0])
        2'd0: cfg_rdata = {23'd0, dec_com[cfg_br], 2'd0, dec_iw[cfg_br], 1'b0, dec_ig[cfg_br]};
        2'd1: cfg_rdata = dec_lo[cfg_br];
        2'd2: cfg_rdata = dec_hi[cfg_br];
        default: cfg_rdata = 32'(dec_pres[cfg_br]);
      endcase
    end else begin
      case (cfg_addr)
        CAW'(0): cfg_rdata = win_base[31:0];
        CAW'(1): cfg_rdata = 32'(win_base[ADDR_W-1:32]);
        CAW'(2): cfg_rdata = size_mb;
        CAW'(3): cfg_rdata = {24'd0, win_iw, 1'b0, win_ig};
        default: cfg_rdata = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base <= '0;
      size_mb  <= '0;
      win_ig   <= '0;
      win_iw   <= '0;
      cfg_err  <= 1'b0;
      for (int i = 0; i < NB; i++) begin
        dec_ig[i]   <= '0;
        dec_iw[i]   <= '0;
        dec_com[i]  <= 1'b0;
        dec_lo[i]   <= '0;
        dec_hi[i]   <= '0;
        dec_pres[i] <= '0;
      end
    end else begin
      cfg_err <= cfg_we && cfg_reject;
      if (cfg_we && !cfg_reject) begin
        if (cfg_is_br) begin
          case (cfg_addr[1:0])
            2'd0: begin
              dec_ig[cfg_br]  <= cfg_wdata[2:0];
              dec_iw[cfg_br]  <= cfg_wdata[5:4];
              dec_com[cfg_br] <= cfg_wdata[8];
            end
            2'd1: dec_lo[cfg_br] <= cfg_wdata;
            2'd2: dec_hi[cfg_br] <= cfg_wdata;
            default: dec_pres[cfg_br] <= cfg_wdata[PORTS-1:0];
          endcase
        end else begin
          case (cfg_addr)
            CAW'(0): win_base[31:0] <= cfg_wdata;
            CAW'(1): win_base[ADDR_W-1:32] <= cfg_wdata[ADDR_W-33:0];
            CAW'(2): size_mb <= cfg_wdata;
            CAW'(3): begin
              win_ig <= cfg_wdata[2:0];
              win_iw <= cfg_wdata[7:4];
            end
            default: ;
          endcase
        end
      end
    end
  end

  wire [ADDR_W-1:0] hpa     = win_base + req_offset;
  wire [SW-1:0]     size_b  = SW'({size_mb, 20'd0});
  wire              in_win  = SW'(req_offset) < size_b;

  wire [ADDR_W-1:0] l1_q    = hpa >> (8 + win_ig);
  wire [BW-1:0]     sel_br  = l1_q[BW-1:0] & BW'((1 << win_iw) - 1);

  wire [ADDR_W-1:0] l2_q    = hpa >> (8 + dec_ig[sel_br]);
  wire [2:0]        tidx    = l2_q[2:0] & 3'((1 << dec_iw[sel_br]) - 1);
  wire [63:0]       tlist   = {dec_hi[sel_br], dec_lo[sel_br]};
  wire [7:0]        sel_port = tlist[{tidx, 3'b000} +: 8];
  wire              port_ok = (sel_port < 8'(PORTS)) && dec_pres[sel_br][sel_port[PW-1:0]];
  wire              hit     = in_win && dec_com[sel_br] && port_ok;

  assign req_ready  = !fwd_valid || fwd_ready;
  assign miss_rdata = 64'd0;
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_write  <= 1'b0;
      fwd_bridge <= '0;
      fwd_port   <= '0;
      fwd_hpa    <= '0;
      fwd_len    <= '0;
      fwd_wdata  <= '0;
      miss_valid <= 1'b0;
      miss_err   <= 1'b0;
    end else begin
      if (fwd_valid && fwd_ready) fwd_valid <= 1'b0;
      miss_valid <= 1'b0;
      miss_err   <= 1'b0;
      if (accept) begin
        if (hit) begin
          fwd_valid  <= 1'b1;
          fwd_write  <= req_write;
          fwd_bridge <= sel_br;
          fwd_port   <= sel_port;
          fwd_hpa    <= hpa;
          fwd_len    <= req_len;
          fwd_wdata  <= req_wdata;
        end else begin
          miss_valid <= 1'b1;
          miss_err   <= !req_write;
        end
      end
    end
  end

  p_size_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    size_mb[7:0] == 8'd0);

  p_win_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_ig <= 3'd6) && (win_iw <= 4'(BW)));

  for (genvar g = 0; g < NB; g++) begin : g_dec_chk
    p_dec_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ig[g] <= 3'd6);
  end

  p_fwd_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_port < 8'(PORTS)));

  p_miss_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (miss_err == !$past(req_write)));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !$rose(fwd_valid));

  p_fwd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_hpa) && $stable(fwd_port)
                                   && $stable(fwd_bridge)));

endmodule

// File: tb/ilv_window_router_tb.sv
module ilv_window_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        req_valid, req_ready, req_write;
  logic [47:0] req_offset;
  logic [2:0]  req_len;
  logic [63:0] req_wdata;
  logic        fwd_valid, fwd_ready, fwd_write;
  logic [1:0]  fwd_bridge;
  logic [7:0]  fwd_port;
  logic [47:0] fwd_hpa;
  logic [2:0]  fwd_len;
  logic [63:0] fwd_wdata;
  logic        miss_valid, miss_err;
  logic [63:0] miss_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_window_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_write(fwd_write),
    .fwd_bridge(fwd_bridge), .fwd_port(fwd_port), .fwd_hpa(fwd_hpa),
    .fwd_len(fwd_len), .fwd_wdata(fwd_wdata),
    .miss_valid(miss_valid), .miss_err(miss_err), .miss_rdata(miss_rdata)
  );

  logic [47:0] s_base;
  logic [31:0] s_size;
  int          s_wig, s_wiw;
  int          s_dig[4], s_diw[4];
  bit          s_com[4];
  logic [31:0] s_lo[4], s_hi[4];
  logic [7:0]  s_pres[4];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic void model(input logic [47:0] off, output bit h,
                                output logic [1:0] b, output logic [7:0] p,
                                output logic [47:0] a);
    logic [2:0]  idx;
    logic [63:0] tl;
    a   = s_base + off;
    b   = 2'((a >> (8 + s_wig)) & ((48'd1 << s_wiw) - 48'd1));
    idx = 3'((a >> (8 + s_dig[b])) & ((48'd1 << s_diw[b]) - 48'd1));
    tl  = {s_hi[b], s_lo[b]};
    p   = tl[idx*8 +: 8];
    h   = (64'(off) < (64'(s_size) << 20)) && s_com[b] && (p < 8'd8) && s_pres[b][p[2:0]];
  endfunction

  task automatic cfg_wr(input int a, input logic [31:0] d, input bit exp_err, input string r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(r, 64'(cfg_err), 64'(exp_err));
  endtask

  task automatic cfg_rd(input int a, output logic [31:0] d);
    cfg_addr = 5'(a);
    #1;
    d = cfg_rdata;
  endtask

  task automatic send(input bit wr, input logic [47:0] off, input logic [2:0] len,
                      input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_route(input string r, input bit wr, input logic [47:0] off);
    bit h; logic [1:0] b; logic [7:0] p; logic [47:0] a;
    model(off, h, b, p, a);
    send(wr, off, 3'd7, 64'h0);
    chk({r, " hit"}, 64'(fwd_valid), 64'(h));
    chk({r, " miss"}, 64'(miss_valid), 64'(!h));
    if (h) begin
      chk({r, " bridge"}, 64'(fwd_bridge), 64'(b));
      chk({r, " port"}, 64'(fwd_port), 64'(p));
      chk({r, " hpa"}, 64'(fwd_hpa), 64'(a));
    end
  endtask

  task automatic set_dec(input int b, input int ig, input int iw, input bit com,
                         input logic [31:0] lo, input logic [31:0] hi, input logic [7:0] pres);
    cfg_wr(8+4*b, 32'(ig) | (32'(iw) << 4) | (32'(com) << 8), 1'b0, "R4 cfg");
    cfg_wr(9+4*b, lo, 1'b0, "R5 cfg");
    cfg_wr(10+4*b, hi, 1'b0, "R5 cfg");
    cfg_wr(11+4*b, 32'(pres), 1'b0, "R6 cfg");
    s_dig[b] = ig; s_diw[b] = iw; s_com[b] = com; s_lo[b] = lo; s_hi[b] = hi; s_pres[b] = pres;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R12 reset fwd_valid", 64'(fwd_valid), 64'd0);
    chk("R12 reset miss_valid", 64'(miss_valid), 64'd0);
    chk("R12 reset req_ready", 64'(req_ready), 64'd1);
    cfg_rd(3, d);
    chk("R3 reset window codes", 64'(d), 64'd0);
    cfg_rd(2, d);
    chk("R10 reset size", 64'(d), 64'd0);
  endtask

  task automatic t_default_gran;
    cfg_wr(0, 32'h2000_0000, 1'b0, "R2 cfg");
    cfg_wr(1, 32'h1, 1'b0, "R2 cfg");
    cfg_wr(2, 32'h400, 1'b0, "R1 legal size");
    s_base = 48'h1_2000_0000; s_size = 32'h400;
    set_dec(0, 0, 0, 1'b1, 32'h0000_0005, 32'h0, 8'hFF);
    send(1'b0, 48'h200, 3'd3, 64'h0);
    chk("R3 default one bridge hit", 64'(fwd_valid), 64'd1);
    chk("R3 default bridge", 64'(fwd_bridge), 64'd0);
    chk("R5 single entry port", 64'(fwd_port), 64'd5);
  endtask

  task automatic t_setup;
    cfg_wr(3, 32'h21, 1'b0, "R3 cfg");
    s_wig = 1; s_wiw = 2;
    set_dec(0, 0, 3, 1'b1, 32'h0302_0100, 32'h0706_0504, 8'hFF);
    set_dec(1, 1, 2, 1'b1, 32'h0103_0507, 32'h0706_0504, 8'hFF);
    set_dec(2, 0, 1, 1'b0, 32'h0302_0100, 32'h0706_0504, 8'hFF);
    set_dec(3, 0, 3, 1'b1, 32'h0122_0300, 32'h0706_0504, 8'h0F);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 40; k++)
      expect_route("R3 R4 R5 R6 sweep", 1'b0, 48'(k) << 8);
    expect_route("R5 high list entry", 1'b0, 48'h0000_0700);
    expect_route("R6 absent port", 1'b0, 48'h0000_0E00);
    expect_route("R4 uncommitted", 1'b0, 48'h0000_0400);
  endtask

  task automatic t_unaligned;
    send(1'b1, 48'h3, 3'd4, 64'h1122_3344_5566_7788);
    chk("R9 fwd valid", 64'(fwd_valid), 64'd1);
    chk("R9 write flag", 64'(fwd_write), 64'd1);
    chk("R9 length", 64'(fwd_len), 64'd4);
    chk("R9 data", fwd_wdata, 64'h1122_3344_5566_7788);
    chk("R2 unaligned hpa", 64'(fwd_hpa), 64'h1_2000_0003);
  endtask

  task automatic t_misses;
    send(1'b0, 48'h400, 3'd7, 64'h0);
    chk("R7 read miss valid", 64'(miss_valid), 64'd1);
    chk("R7 read miss err", 64'(miss_err), 64'd1);
    chk("R7 read miss data", miss_rdata, 64'd0);
    chk("R7 nothing forwarded", 64'(fwd_valid), 64'd0);
    send(1'b1, 48'h400, 3'd7, 64'hDEAD_BEEF);
    chk("R8 write miss valid", 64'(miss_valid), 64'd1);
    chk("R8 write miss ok", 64'(miss_err), 64'd0);
    chk("R8 nothing forwarded", 64'(fwd_valid), 64'd0);
  endtask

  task automatic t_window_edge;
    send(1'b0, 48'h4000_0000, 3'd0, 64'h0);
    chk("R10 at size miss", 64'(miss_valid), 64'd1);
    chk("R10 at size no fwd", 64'(fwd_valid), 64'd0);
    expect_route("R10 last line", 1'b0, 48'h3FFF_FF00);
  endtask

  task automatic t_size_reject;
    logic [31:0] d;
    cfg_wr(2, 32'h401, 1'b1, "R1 odd size refused");
    cfg_rd(2, d);
    chk("R1 size kept", 64'(d), 64'h400);
    send(1'b0, 48'h4000_0000, 3'd0, 64'h0);
    chk("R1 refused size no effect", 64'(miss_valid), 64'd1);
    cfg_wr(2, 32'h500, 1'b0, "R1 larger size");
    s_size = 32'h500;
    cfg_rd(2, d);
    chk("R1 size stored", 64'(d), 64'h500);
    expect_route("R10 grown window", 1'b0, 48'h4000_0000);
  endtask

  task automatic t_code_reject;
    logic [31:0] d;
    cfg_wr(8, 32'h137, 1'b1, "R11 decoder gran 7");
    cfg_rd(8, d);
    chk("R11 decoder kept", 64'(d), 64'h130);
    cfg_wr(3, 32'h31, 1'b1, "R11 window ways 3");
    cfg_rd(3, d);
    chk("R11 window kept", 64'(d), 64'h21);
    expect_route("R11 routing unchanged", 1'b0, 48'h0000_0A00);
  endtask

  task automatic t_backpressure;
    logic [47:0] held;
    fwd_ready = 1'b0;
    send(1'b0, 48'h0, 3'd7, 64'h0);
    chk("R12 stalled valid", 64'(fwd_valid), 64'd1);
    held = fwd_hpa;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = 48'h100;
    chk("R12 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R12 hpa held", 64'(fwd_hpa), 64'(held));
    chk("R12 still valid", 64'(fwd_valid), 64'd1);
    fwd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 next taken", 64'(fwd_hpa), 64'h1_2000_0100);
    chk("R12 next valid", 64'(fwd_valid), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_len = '0; req_wdata = '0;
    fwd_ready = 1'b1;
    s_base = '0; s_size = '0; s_wig = 0; s_wiw = 0;
    for (int i = 0; i < 4; i++) begin
      s_dig[i] = 0; s_diw[i] = 0; s_com[i] = 0; s_lo[i] = 0; s_hi[i] = 0; s_pres[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_default_gran;
    t_setup;
    t_sweep;
    t_unaligned;
    t_misses;
    t_window_edge;
    t_size_reject;
    t_code_reject;
    t_backpressure;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule